// File: doc/BRIEF.md
# Box Low-Pass Splitter for Raster Video

This block takes a raster video stream, one pixel per clock, and splits every pixel into two parts. The low-frequency part is the mean of a rectangular window of 2^N lines by 2^M columns. The high-frequency part is the pixel minus that mean. A pixel-level correction stage downstream needs this separation: it works on the high-frequency part and then adds the low-frequency part back. The window is averaged with running sums, and every division is a right shift, so the arithmetic cost stays fixed for any window size.

The input bus carries pixel data, an active-video qualifier, and single-cycle line-start (`inHsync`) and frame-start (`inVsync`) pulses. A sync pulse never falls on an active cycle. Each frame is one `inVsync` pulse followed by lines. Each line is one `inHsync` pulse followed by its active pixels, with idle cycles allowed between them.

The row index i counts the `inHsync` pulses after `inVsync`, starting at 0. The column index j counts the active pixels since the last `inHsync`, starting at 0. Lines are stored at a power-of-two pitch of 2^P pixels. The output for a window is placed at its centre. Pixels whose window would leave the image are cropped rather than padded.

Top module: `box_lowpass_splitter`

## Requirements
- R1: For an input pixel at (i,j) with a full window, `lfData` equals floor(S / 2^(N+M)), where S is the exact sum of the input pixels in rows i-2^N+1..i and columns j-2^M+1..j of the current frame. The output stands for the pixel at (i-2^(N-1), j-2^(M-1)).
- R2: `hfData` is a (DATA_W+1)-bit two's-complement value equal to the input pixel at (i-2^(N-1), j-2^(M-1)) minus the `lfData` of the same output.
- R3: An output is produced for exactly those input pixels with i >= 2^N-1 and j >= 2^M-1, one output per such pixel. No other input produces an output.
- R4: An output appears with `outValid` high for one cycle, right after the second rising edge that follows the edge sampling its input pixel.
- R5: `outLineStart` is high with the output whose input column is j = 2^M-1, and never without `outValid`.
- R6: `outFrameStart` is high only with the output whose input is at (2^N-1, 2^M-1), and it always comes with `outLineStart`.
- R7: After `inVsync`, no pixel of an earlier frame affects any output: column sums and line storage restart with row 0.
- R8: After `inHsync`, the horizontal running sum restarts, so columns of the previous line do not leak into the new line.
- R9: No intermediate sum overflows. A frame of all-maximum pixels gives `lfData` = 2^DATA_W-1 and `hfData` = 0.
- R10: Idle cycles (`inActive` low) between pixels of a line produce no output and do not change any result.
- R11: Line widths from 2^M up to 2^P pixels are handled, and lines narrower than the pitch give the same results as a full-width image of that width.
- R12: While reset is held and after its release, `outValid`, `outLineStart` and `outFrameStart` are low and `lfData` and `hfData` are zero until the first output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | DATA_W | Input pixel value |
| inActive | input | 1 | Input pixel valid |
| inHsync | input | 1 | Line-start pulse on an idle cycle |
| inVsync | input | 1 | Frame-start pulse on an idle cycle |
| lfData | output | DATA_W | Window average (low-frequency part) |
| hfData | output | DATA_W+1 | Centre pixel minus average, two's complement |
| outValid | output | 1 | Output pair valid |
| outLineStart | output | 1 | First output of an output line |
| outFrameStart | output | 1 | First output of a frame |

## Verification
A corrupted column sum stays in the column memory, so it shows in `lfData` on the next output of that column and on every later one in the frame. A corrupted horizontal sum shows at once and persists until the next line start. A wrong line-storage slot appears after 2^N lines as a column-sum error, and within half a window as a wrong `hfData`. The bench compares every cycle against a behavioural window-sum model, using frames built to expose these faults. Full-scale frames expose overflow. A zero frame after a full-scale one exposes stale state. A horizontal ramp with a jump at each line end exposes leakage between lines. Idle gaps expose pipeline misalignment.

// File: rtl/boxsplit_pkg.sv
`timescale 1ns/1ps
package boxsplit_pkg;

  // Per-pixel strobes from the control unit to the datapath, aligned with
  // the registered input pixel.
  typedef struct packed {
    logic pixValid;      // an accepted pixel sits in the input register
    logic firstRow;      // row 0 of the frame: column sums restart
    logic oldValid;      // the line slot holds a pixel of this frame
    logic lineStart;     // column 0: horizontal sum restarts
    logic histValid;     // a column sum 2^M columns back exists
    logic winReady;      // full window available: emit output
    logic outLineFirst;  // first output of an output line
    logic outFrameFirst; // first output of the frame
  } strobe_t;

endpackage

// File: rtl/boxsplit_ctrl.sv
`timescale 1ns/1ps
module boxsplit_ctrl
  import boxsplit_pkg::*;
#(
  parameter int LOG_ROWS  = 2,
  parameter int LOG_COLS  = 3,
  parameter int LOG_PITCH = 5,
  parameter int ROW_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inActive,
  input  logic                 inHsync,
  input  logic                 inVsync,
  output strobe_t              strb,
  output logic [LOG_PITCH-1:0] curCol,
  output logic [LOG_ROWS-1:0]  curSlot
);

  localparam int WIN_H = 1 << LOG_ROWS;
  localparam int WIN_W = 1 << LOG_COLS;
  localparam int COL_W = LOG_PITCH + 1;

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic             waitFirstLine;
  logic             accept;

  // Pixels beyond the line pitch are not accepted.
  assign accept = inActive && !colCnt[LOG_PITCH];

  // Raster position counters
  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt        <= '0;
      rowCnt        <= '0;
      waitFirstLine <= 1'b1;
    end else if (inVsync) begin
      colCnt        <= '0;
      rowCnt        <= '0;
      waitFirstLine <= 1'b1;
    end else if (inHsync) begin
      colCnt <= '0;
      if (waitFirstLine) waitFirstLine <= 1'b0;
      else               rowCnt        <= rowCnt + ROW_W'(1);
    end else if (accept) begin
      colCnt <= colCnt + COL_W'(1);
    end
  end

  // Strobes aligned with the datapath input register
  always_ff @(posedge clk) begin
    if (rst) begin
      strb    <= '0;
      curCol  <= '0;
      curSlot <= '0;
    end else begin
      strb.pixValid      <= accept;
      strb.firstRow      <= (rowCnt == '0);
      strb.oldValid      <= (rowCnt >= ROW_W'(WIN_H));
      strb.lineStart     <= (colCnt == '0);
      strb.histValid     <= (colCnt >= COL_W'(WIN_W));
      strb.winReady      <= (rowCnt >= ROW_W'(WIN_H - 1)) && (colCnt >= COL_W'(WIN_W - 1));
      strb.outLineFirst  <= (rowCnt >= ROW_W'(WIN_H - 1)) && (colCnt == COL_W'(WIN_W - 1));
      strb.outFrameFirst <= (rowCnt == ROW_W'(WIN_H - 1)) && (colCnt == COL_W'(WIN_W - 1));
      curCol             <= colCnt[LOG_PITCH-1:0];
      curSlot            <= rowCnt[LOG_ROWS-1:0];
    end
  end

endmodule

// File: rtl/boxsplit_datapath.sv
`timescale 1ns/1ps
module boxsplit_datapath
  import boxsplit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOG_ROWS  = 2,
  parameter int LOG_COLS  = 3,
  parameter int LOG_PITCH = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    inData,
  input  strobe_t              strb,
  input  logic [LOG_PITCH-1:0] curCol,
  input  logic [LOG_ROWS-1:0]  curSlot,
  output logic [DATA_W-1:0]    lfData,
  output logic [DATA_W:0]      hfData,
  output logic                 outValid,
  output logic                 outLineStart,
  output logic                 outFrameStart
);

  localparam int WIN_W      = 1 << LOG_COLS;
  localparam int HALF_H     = 1 << (LOG_ROWS - 1);
  localparam int HALF_W     = 1 << (LOG_COLS - 1);
  localparam int PITCH      = 1 << LOG_PITCH;
  localparam int ADDR_W     = LOG_ROWS + LOG_PITCH;
  localparam int LINE_DEPTH = 1 << ADDR_W;
  localparam int COL_SUM_W  = DATA_W + LOG_ROWS;
  localparam int ROW_SUM_W  = COL_SUM_W + LOG_COLS;

  // ---- stage A: registered pixel, memory access, column update ----
  logic [DATA_W-1:0]    pixA;
  logic [DATA_W-1:0]    lineMem [LINE_DEPTH];
  logic [COL_SUM_W-1:0] colMem  [PITCH];

  logic [ADDR_W-1:0]    wrAddr;
  logic [ADDR_W-1:0]    ctrAddr;
  logic [DATA_W-1:0]    oldPix;
  logic [COL_SUM_W-1:0] baseSum;
  logic [COL_SUM_W-1:0] newColSum;

  always_ff @(posedge clk) begin
    if (rst) pixA <= '0;
    else     pixA <= inData;
  end

  assign wrAddr  = {curSlot, curCol};
  assign ctrAddr = {curSlot - LOG_ROWS'(HALF_H), curCol - LOG_PITCH'(HALF_W)};

  always_comb begin
    oldPix    = strb.oldValid ? lineMem[wrAddr] : '0;
    baseSum   = strb.firstRow ? '0 : colMem[curCol];
    // Exact column sum: the true result always fits, so modular math is exact.
    newColSum = baseSum + COL_SUM_W'(pixA) - COL_SUM_W'(oldPix);
  end

  always_ff @(posedge clk) begin
    if (strb.pixValid) begin
      lineMem[wrAddr] <= pixA;
      colMem[curCol]  <= newColSum;
    end
  end

  // ---- stage B: horizontal running sum ----
  logic                 bValid;
  logic                 bLineStart;
  logic                 bHistValid;
  logic                 bWinReady;
  logic                 bLineFirst;
  logic                 bFrameFirst;
  logic [COL_SUM_W-1:0] bColSum;
  logic [DATA_W-1:0]    bCentre;

  always_ff @(posedge clk) begin
    if (rst) begin
      bValid      <= 1'b0;
      bLineStart  <= 1'b0;
      bHistValid  <= 1'b0;
      bWinReady   <= 1'b0;
      bLineFirst  <= 1'b0;
      bFrameFirst <= 1'b0;
      bColSum     <= '0;
      bCentre     <= '0;
    end else begin
      bValid      <= strb.pixValid;
      bLineStart  <= strb.lineStart;
      bHistValid  <= strb.histValid;
      bWinReady   <= strb.winReady;
      bLineFirst  <= strb.outLineFirst;
      bFrameFirst <= strb.outFrameFirst;
      bColSum     <= newColSum;
      bCentre     <= lineMem[ctrAddr];
    end
  end

  // Column sums of the last 2^M columns; entry k is k+1 columns back.
  logic [COL_SUM_W-1:0] colHist [WIN_W];

  always_ff @(posedge clk) begin
    if (bValid) begin
      colHist[0] <= bColSum;
      for (int k = 1; k < WIN_W; k++) colHist[k] <= colHist[k-1];
    end
  end

  logic [ROW_SUM_W-1:0] rowSum;
  logic [ROW_SUM_W-1:0] rowSumNext;
  logic [DATA_W-1:0]    lfNext;
  logic [DATA_W:0]      hfNext;

  always_comb begin
    rowSumNext = (bLineStart ? '0 : rowSum) + ROW_SUM_W'(bColSum)
               - (bHistValid ? ROW_SUM_W'(colHist[WIN_W-1]) : '0);
    lfNext     = rowSumNext[ROW_SUM_W-1 -: DATA_W];
    hfNext     = {1'b0, bCentre} - {1'b0, lfNext};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowSum        <= '0;
      lfData        <= '0;
      hfData        <= '0;
      outValid      <= 1'b0;
      outLineStart  <= 1'b0;
      outFrameStart <= 1'b0;
    end else begin
      outValid      <= bValid && bWinReady;
      outLineStart  <= bValid && bLineFirst;
      outFrameStart <= bValid && bFrameFirst;
      if (bValid) rowSum <= rowSumNext;
      if (bValid && bWinReady) begin
        lfData <= lfNext;
        hfData <= hfNext;
      end
    end
  end

endmodule

// File: rtl/box_lowpass_splitter.sv
`timescale 1ns/1ps
module box_lowpass_splitter
  import boxsplit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOG_ROWS  = 2,
  parameter int LOG_COLS  = 3,
  parameter int LOG_PITCH = 5,
  parameter int ROW_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inActive,
  input  logic              inHsync,
  input  logic              inVsync,
  output logic [DATA_W-1:0] lfData,
  output logic [DATA_W:0]   hfData,
  output logic              outValid,
  output logic              outLineStart,
  output logic              outFrameStart
);

  strobe_t              strb;
  logic [LOG_PITCH-1:0] curCol;
  logic [LOG_ROWS-1:0]  curSlot;

  boxsplit_ctrl #(
    .LOG_ROWS (LOG_ROWS),
    .LOG_COLS (LOG_COLS),
    .LOG_PITCH(LOG_PITCH),
    .ROW_W    (ROW_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inActive(inActive),
    .inHsync (inHsync),
    .inVsync (inVsync),
    .strb    (strb),
    .curCol  (curCol),
    .curSlot (curSlot)
  );

  boxsplit_datapath #(
    .DATA_W   (DATA_W),
    .LOG_ROWS (LOG_ROWS),
    .LOG_COLS (LOG_COLS),
    .LOG_PITCH(LOG_PITCH)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .inData       (inData),
    .strb         (strb),
    .curCol       (curCol),
    .curSlot      (curSlot),
    .lfData       (lfData),
    .hfData       (hfData),
    .outValid     (outValid),
    .outLineStart (outLineStart),
    .outFrameStart(outFrameStart)
  );

endmodule

// File: rtl/boxsplit_checker.sv
`timescale 1ns/1ps
module boxsplit_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inActive,
  input logic [DATA_W-1:0] lfData,
  input logic [DATA_W:0]   hfData,
  input logic              outValid,
  input logic              outLineStart,
  input logic              outFrameStart
);

  // Centre pixel rebuilt from the two output parts must be a legal pixel.
  logic [DATA_W+1:0] centreRebuilt;
  assign centreRebuilt = {hfData[DATA_W], hfData} + {2'b00, lfData};

  assert_centre_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (centreRebuilt[DATA_W+1:DATA_W] == 2'b00));

  assert_output_from_pixel_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inActive, 3));

  assert_idle_gives_nothing_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(inActive, 3) |-> !outValid);

  assert_line_marker_valid_R5: assert property (@(posedge clk) disable iff (rst)
    outLineStart |-> outValid);

  assert_frame_marker_line_R6: assert property (@(posedge clk) disable iff (rst)
    outFrameStart |-> (outLineStart && outValid));

endmodule

bind box_lowpass_splitter boxsplit_checker #(.DATA_W(DATA_W)) i_checker (
  .clk          (clk),
  .rst          (rst),
  .inActive     (inActive),
  .lfData       (lfData),
  .hfData       (hfData),
  .outValid     (outValid),
  .outLineStart (outLineStart),
  .outFrameStart(outFrameStart)
);

// File: tb/test_box_lowpass_splitter.sv
`timescale 1ns/1ps
module test_box_lowpass_splitter;

  localparam int DATA_W = 8;
  localparam int LR     = 2;
  localparam int LC     = 3;
  localparam int LP     = 5;
  localparam int WH     = 1 << LR;
  localparam int WW     = 1 << LC;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] inData = '0;
  logic              inActive = 1'b0;
  logic              inHsync = 1'b0;
  logic              inVsync = 1'b0;
  logic [DATA_W-1:0] lfData;
  logic [DATA_W:0]   hfData;
  logic              outValid;
  logic              outLineStart;
  logic              outFrameStart;

  box_lowpass_splitter #(
    .DATA_W(DATA_W), .LOG_ROWS(LR), .LOG_COLS(LC), .LOG_PITCH(LP), .ROW_W(12)
  ) i_box_lowpass_splitter (
    .clk(clk), .rst(rst), .inData(inData), .inActive(inActive),
    .inHsync(inHsync), .inVsync(inVsync), .lfData(lfData), .hfData(hfData),
    .outValid(outValid), .outLineStart(outLineStart), .outFrameStart(outFrameStart)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    due;
    int    lf;
    int    hf;
    bit    ls;
    bit    fs;
    string req;
  } exp_t;

  exp_t  expQ[$];
  int    frame[16][32];
  int    cycleCount = 0;
  int    vectors = 0;
  int    miscompares = 0;
  bit    monOn = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               req, what, act, expv, cycleCount);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Cycle-by-cycle comparison against the expected-output queue
  always @(negedge clk) begin
    if (monOn) begin
      if (expQ.size() > 0 && expQ[0].due == cycleCount) begin
        exp_t e;
        int   hfAct;
        e = expQ.pop_front();
        hfAct = $signed(hfData);
        check(outValid == 1'b1, "R4", "outValid", int'(outValid), 1);
        if (outValid) begin
          check(int'(lfData) == e.lf, e.req, "lfData", int'(lfData), e.lf);
          check(hfAct == e.hf, "R2", "hfData", hfAct, e.hf);
          check(outLineStart == e.ls, "R5", "outLineStart", int'(outLineStart), int'(e.ls));
          check(outFrameStart == e.fs, "R6", "outFrameStart", int'(outFrameStart), int'(e.fs));
        end
      end else begin
        // R3 / R10: no output where none is due
        check(outValid == 1'b0, "R3", "outValid", int'(outValid), 0);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cycleCount == 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cycleCount, 0);
      summary();
      $finish;
    end
  end

  // mode 0 random, 1 all maximum, 2 all zero, 3 ramp along the line
  task automatic runFrame(input int h, input int w, input int mode,
                          input int gapPct, input string lfReq);
    for (int i = 0; i < h; i++)
      for (int j = 0; j < w; j++)
        case (mode)
          0:       frame[i][j] = int'($urandom_range(0, 255));
          1:       frame[i][j] = 255;
          2:       frame[i][j] = 0;
          default: frame[i][j] = (j * 8 + i) % 256;
        endcase
    inVsync = 1'b1;
    @(negedge clk);
    inVsync = 1'b0;
    @(negedge clk);
    for (int i = 0; i < h; i++) begin
      inHsync = 1'b1;
      @(negedge clk);
      inHsync = 1'b0;
      for (int j = 0; j < w; j++) begin
        while (int'($urandom_range(0, 99)) < gapPct) begin
          inActive = 1'b0;
          @(negedge clk);
        end
        inActive = 1'b1;
        inData   = DATA_W'(frame[i][j]);
        if (i >= WH - 1 && j >= WW - 1) begin
          exp_t e;
          int   sum = 0;
          for (int r = i - WH + 1; r <= i; r++)
            for (int c = j - WW + 1; c <= j; c++)
              sum += frame[r][c];
          e.due = cycleCount + 3;
          e.lf  = sum >> (LR + LC);
          e.hf  = frame[i - WH/2][j - WW/2] - e.lf;
          e.ls  = (j == WW - 1);
          e.fs  = (j == WW - 1) && (i == WH - 1);
          e.req = lfReq;
          expQ.push_back(e);
        end
        @(negedge clk);
      end
      inActive = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: quiet outputs after reset
    check(outValid == 1'b0, "R12", "outValid", int'(outValid), 0);
    check(lfData == '0, "R12", "lfData", int'(lfData), 0);
    check(hfData == '0, "R12", "hfData", int'(hfData), 0);
    check(outFrameStart == 1'b0 && outLineStart == 1'b0, "R12", "markers",
          int'(outFrameStart) + int'(outLineStart), 0);
    monOn = 1'b1;

    runFrame(12, 32, 0, 0,  "R1");   // full pitch, random
    runFrame(9,  20, 0, 0,  "R11");  // narrower than the pitch
    runFrame(6,  32, 1, 0,  "R9");   // all maximum
    runFrame(7,  16, 2, 10, "R7");   // zeros right after maximum
    runFrame(10, 32, 0, 30, "R10");  // idle gaps inside lines
    runFrame(8,  24, 3, 0,  "R8");   // ramp with a jump at each line end

    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R3", "pending outputs", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule